// File: doc/BRIEF.md
# Local Bus Interrupt Controller

This block gathers sixteen level-sensitive interrupt request lines from peripherals on a local bus and merges them into a single interrupt output for the processor. Every request line passes through a two-stage synchroniser into a status register. Each status bit follows the level of its line: it is set while the line is high and clears as soon as the line goes low. An enable mask gates the status bits. The output interrupt is asserted whenever at least one status bit and its mask bit are both set.

Software uses a small register window with 16-bit accesses. The source register at byte offset 0x000 does not return a bitmap. It returns an encoded value: the index of the lowest-numbered pending and enabled request plus one, shifted left by two bits, or zero when nothing is pending. The mask register at byte offset 0x002 can be read and written. The output interrupt is driven by a two-state machine with the states IRQ_QUIET and IRQ_ACTIVE. The transition RAISE moves it from IRQ_QUIET to IRQ_ACTIVE when a gated request exists. The transition DROP moves it back to IRQ_QUIET when no gated request remains. The machine stays in its current state otherwise.

Top module: `lbus_irq_ctrl`

## Requirements
- R1: A rising request line sets its status bit on the second clock edge after the change, and the output interrupt follows on the third edge.
- R2: `irq_o` is high exactly when, at the previous clock edge, the bitwise AND of status and mask was non-zero.
- R3: A read at byte offset 0x000 returns ((n+1) << 2), where n is the lowest-numbered bit set in both status and mask. Examples are 16 for bit 3, 40 for bit 9 and 64 for bit 15. The read returns 0 when no such bit exists.
- R4: A write at byte offset 0x002 loads the mask on its clock edge. The output interrupt reflects the new mask on the following edge. A read at 0x002 returns the mask.
- R5: After reset the mask is 0x0010, the status is zero, `irq_o` is low and `bus_rdata_o` is zero.
- R6: Reads at any other offset return zero. Writes to any other offset leave both the mask and the source register unchanged.
- R7: Read data appears on `bus_rdata_o` on the edge after the cycle where `bus_rd_i` is high. In any cycle that follows one without a read strobe, `bus_rdata_o` is zero.
- R8: When a request line falls, its status bit clears after the same two-edge delay. No request is latched, so the source register and the output interrupt return to zero.
- R9: A read and a write to the mask in the same cycle return the mask value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | 16 | Level-sensitive request lines, asynchronous to clk |
| bus_addr_i | input | 12 | Byte offset of the register access |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Combined interrupt output |

## Verification
A mask write and a status change can land on the same clock edge. The output state machine then has to decide RAISE or DROP from both new values together. The bench provokes this by raising a request line one cycle before it issues a mask write that enables that line, so the synchronised status bit and the new mask bit both arrive on one edge. It then checks that `irq_o` is still low right after that edge and high one edge later. A second case collides a mask read with a mask write in the same cycle, and the bench checks that the read returns the value from before the write.

// File: rtl/lbic_pkg.sv
package lbic_pkg;
    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_ACTIVE = 1'b1
    } irq_state_e;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_SRC  = 2'd1,
        SEL_MASK = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/lbic_sync.sv
module lbic_sync #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    logic [N-1:0] stage1;

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1[g] <= 1'b0;
                sync_o[g] <= 1'b0;
            end else begin
                stage1[g] <= async_i[g];
                sync_o[g] <= stage1[g];
            end
        end
    end
endmodule

// File: rtl/lbic_prio.sv
module lbic_prio #(
    parameter int N      = 16,
    parameter int CODE_W = $clog2(N + 1) + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      pend_i,
    output logic [CODE_W-1:0] code_o
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    always_comb begin
        code_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i]) code_o = CODE_W'((i + 1) << 2);
        end
    end

    logic [IDX_W-1:0] chk_idx;
    assign chk_idx = IDX_W'((code_o >> 2) - 1);

    // R3
    src_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_i == '0) |-> (code_o == '0));

    // R3
    src_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o != '0) |-> (pend_i[chk_idx] &&
            ((pend_i & ~({N{1'b1}} << chk_idx)) == '0)));
endmodule

// File: rtl/lbic_irq_fsm.sv
module lbic_irq_fsm
    import lbic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gated_any_i,
    output logic irq_o
);
    irq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (gated_any_i)  state_d = IRQ_ACTIVE; // RAISE
            IRQ_ACTIVE: if (!gated_any_i) state_d = IRQ_QUIET;  // DROP
            default:                      state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_o = (state_q == IRQ_ACTIVE);
    end
endmodule

// File: rtl/lbic_regif.sv
module lbic_regif
    import lbic_pkg::*;
#(
    parameter int          N           = 16,
    parameter int          ADDR_W      = 12,
    parameter int          DATA_W      = 16,
    parameter int          CODE_W      = 7,
    parameter logic [11:0] SRC_OFFSET  = 12'h000,
    parameter logic [11:0] MASK_OFFSET = 12'h002,
    parameter logic [15:0] MASK_RESET  = 16'h0010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [N-1:0]      mask_o,
    output logic [DATA_W-1:0] rdata_o
);
    reg_sel_e sel;

    always_comb begin
        if (addr_i == ADDR_W'(SRC_OFFSET))       sel = SEL_SRC;
        else if (addr_i == ADDR_W'(MASK_OFFSET)) sel = SEL_MASK;
        else                                     sel = SEL_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       mask_o <= N'(MASK_RESET);
        else if (wr_i && sel == SEL_MASK) mask_o <= N'(wdata_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (rd_i) begin
            unique case (sel)
                SEL_SRC:  rdata_o <= DATA_W'(code_i);
                SEL_MASK: rdata_o <= DATA_W'(mask_o);
                default:  rdata_o <= '0;
            endcase
        end else begin
            rdata_o <= '0;
        end
    end

    // R4
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == ADDR_W'(MASK_OFFSET)) |=> (mask_o == $past(N'(wdata_i))));

    // R6
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && addr_i == ADDR_W'(MASK_OFFSET)) |=> $stable(mask_o));

    // R7
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> (rdata_o == '0));
endmodule

// File: rtl/lbus_irq_ctrl.sv
module lbus_irq_ctrl #(
    parameter int          N           = 16,
    parameter int          ADDR_W      = 12,
    parameter int          DATA_W      = 16,
    parameter logic [11:0] SRC_OFFSET  = 12'h000,
    parameter logic [11:0] MASK_OFFSET = 12'h002,
    parameter logic [15:0] MASK_RESET  = 16'h0010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      irq_req_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);
    localparam int CODE_W = $clog2(N + 1) + 2;

    logic [N-1:0]      status;
    logic [N-1:0]      mask;
    logic [N-1:0]      gated;
    logic [CODE_W-1:0] src_code;

    lbic_sync #(.N(N)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_req_i),
        .sync_o  (status)
    );

    assign gated = status & mask;

    lbic_prio #(.N(N), .CODE_W(CODE_W)) u_prio (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (gated),
        .code_o (src_code)
    );

    lbic_regif #(
        .N(N), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W),
        .SRC_OFFSET(SRC_OFFSET), .MASK_OFFSET(MASK_OFFSET), .MASK_RESET(MASK_RESET)
    ) u_regif (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (bus_addr_i),
        .wr_i    (bus_wr_i),
        .rd_i    (bus_rd_i),
        .wdata_i (bus_wdata_i),
        .code_i  (src_code),
        .mask_o  (mask),
        .rdata_o (bus_rdata_o)
    );

    lbic_irq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .gated_any_i (|gated),
        .irq_o       (irq_o)
    );

    // R2
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == ($past(status & mask) != '0));

    // R1
    status_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status != $past(status)) |-> (status == $past(u_sync.stage1)));
endmodule

// File: tb/sim_lbus_irq_ctrl.sv
module sim_lbus_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_req_i = '0;
    logic [11:0] bus_addr_i = '0;
    logic        bus_wr_i = 1'b0;
    logic        bus_rd_i = 1'b0;
    logic [15:0] bus_wdata_i = '0;
    logic [15:0] bus_rdata_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    lbus_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req_i),
        .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [15:0] d);
        bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
        tick();
        bus_wr_i = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [15:0] d);
        bus_addr_i = a; bus_rd_i = 1'b1;
        tick();
        bus_rd_i = 1'b0;
        d = bus_rdata_o;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        chk("R5 irq after reset", {15'b0, irq_o}, 16'h0);
        chk("R5 rdata after reset", bus_rdata_o, 16'h0);
        bus_read(12'h002, v); chk("R5 mask reset", v, 16'h0010);
        bus_read(12'h000, v); chk("R5 source reset", v, 16'h0);
    endtask

    task automatic t_level();
        logic [15:0] v;
        irq_req_i = 16'h0010;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R1 irq not yet after two edges", {15'b0, irq_o}, 16'h0);
        tick();
        chk("R1 irq on third edge", {15'b0, irq_o}, 16'h1);
        bus_read(12'h000, v); chk("R3 source bit4", v, 16'd20);
        irq_req_i = 16'h0000;
        tick(); tick(); tick();
        chk("R8 irq drops with line", {15'b0, irq_o}, 16'h0);
        bus_read(12'h000, v); chk("R8 source cleared", v, 16'h0);
    endtask

    task automatic t_prio();
        logic [15:0] v;
        bus_write(12'h002, 16'hFFFF);
        bus_read(12'h002, v); chk("R4 mask readback", v, 16'hFFFF);
        irq_req_i = 16'h0208;
        tick(); tick(); tick();
        bus_read(12'h000, v); chk("R3 lowest of bits 3,9", v, 16'd16);
        bus_write(12'h002, 16'hFE00);
        bus_read(12'h000, v); chk("R3 bit9 after mask", v, 16'd40);
        irq_req_i = 16'h8000;
        bus_write(12'h002, 16'h8000);
        tick(); tick();
        bus_read(12'h000, v); chk("R3 bit15", v, 16'd64);
        chk("R2 irq with bit15", {15'b0, irq_o}, 16'h1);
        bus_write(12'h002, 16'h0000);
        chk("R4 irq one edge after mask write", {15'b0, irq_o}, 16'h1);
        tick();
        chk("R4 irq dropped by mask", {15'b0, irq_o}, 16'h0);
        bus_read(12'h000, v); chk("R3 masked source zero", v, 16'h0);
        irq_req_i = 16'h0000;
        tick(); tick(); tick();
    endtask

    task automatic t_other();
        logic [15:0] v;
        bus_write(12'h002, 16'h0001);
        irq_req_i = 16'h0001;
        tick(); tick(); tick();
        bus_write(12'h004, 16'hFFFF);
        bus_write(12'h000, 16'h0000);
        bus_read(12'h002, v); chk("R6 mask unchanged", v, 16'h0001);
        bus_read(12'h000, v); chk("R6 source unchanged", v, 16'd4);
        bus_read(12'h004, v); chk("R6 read other zero", v, 16'h0);
        bus_read(12'h006, v); chk("R6 read 0x006 zero", v, 16'h0);
        bus_read(12'h002, v);
        tick();
        chk("R7 rdata zero when idle", bus_rdata_o, 16'h0);
        irq_req_i = 16'h0000;
        tick(); tick(); tick();
    endtask

    task automatic t_same();
        bus_addr_i = 12'h002; bus_wdata_i = 16'h1234;
        bus_wr_i = 1'b1; bus_rd_i = 1'b1;
        tick();
        bus_wr_i = 1'b0; bus_rd_i = 1'b0;
        chk("R9 read returns old mask", bus_rdata_o, 16'h0001);
        bus_read(12'h002, bus_wdata_i);
        chk("R9 new mask stored", bus_wdata_i, 16'h1234);
    endtask

    task automatic t_collide();
        bus_write(12'h002, 16'h0000);
        irq_req_i = 16'h0001;
        tick();
        bus_write(12'h002, 16'h0001);
        chk("R2 irq low right after joint edge", {15'b0, irq_o}, 16'h0);
        tick();
        chk("R2 irq high one edge later", {15'b0, irq_o}, 16'h1);
        irq_req_i = 16'h0000;
        tick(); tick(); tick();
        chk("R8 irq low after release", {15'b0, irq_o}, 16'h0);
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_level();
        t_prio();
        t_other();
        t_same();
        t_collide();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule